// File: doc/BRIEF.md
# Interrupt Flag and Mask Register Group

This block holds the interrupt flags of a two-wire serial bus controller and merges them into a single interrupt line. Single-cycle event pulses from the surrounding controller logic set sticky flag bits. Software reads the flags and clears any subset by writing ones to them. Each source also has a mask bit. Software cannot write the mask as a whole. It unmasks sources by writing ones to a set-only address and masks them by writing ones to a clear-only address. The current mask can be read back.

The group also contains the detector for the stretch-timeout event. While the bus is held in a stretched state, a counter runs against an 8-bit limit that software can program. When the stretch lasts longer than the limit, the detector raises the timeout flag. The interrupt output is a registered OR of every flag whose mask bit is open. Register access uses one write strobe with an address and data, and a combinational read port selected by a separate read address.

Top module: `irq_reg_group`

## Requirements
- R1: After reset all flags read 0, the mask reads 0x2FF (every implemented source masked), the timeout limit reads 0xFF and `irq` is low.
- R2: A high `evtIn` bit in a clock cycle sets the flag at that same bit position. The flag stays set after the pulse ends until software clears it. Flag positions: 0 transfer complete, 1 data threshold, 2 no acknowledge, 3 stretch timeout, 4 target ready, 5 receive overflow, 6 transmit overflow, 7 receive underflow, 9 arbitration lost.
- R3: A write to address 0x10 (flags) clears exactly the flag bits that are one in the written data. All other flags are left unchanged.
- R4: If an event and a clear hit the same flag in the same cycle, the event wins and the flag stays set.
- R5: A write to address 0x24 opens the mask for each bit that is one in the data. All other mask bits are left unchanged. The mask reads back at address 0x20, where 1 means masked.
- R6: A write to address 0x28 closes the mask for each bit that is one in the data. All other mask bits are left unchanged.
- R7: `irq` is high exactly one cycle after some flag is set while its mask bit is open, and low one cycle after no such flag remains.
- R8: Bit 8 is reserved. Its event input has no effect, and it reads 0 in both the flag and mask registers.
- R9: Data bits [7:0] written to address 0x1C load the timeout limit, which reads back at 0x1C. If `busStretch` stays high for more than limit consecutive clock edges, flag 3 is set. A stretch of limit edges or fewer sets nothing.
- R10: A stretch episode raises the timeout at most once. Once flag 3 is cleared during a continuing stretch, it is not set again until `busStretch` has dropped.
- R11: A write to any other address changes no flag, mask or limit bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrAddr | input | 8 | Write byte address |
| wrData | input | 10 | Write data |
| rdAddr | input | 8 | Read byte address |
| rdData | output | 10 | Read data, combinational from rdAddr |
| evtIn | input | 10 | Event pulses from the controller, one bit per source |
| busStretch | input | 1 | High while the bus is held stretched |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench uses the default parameters: ten source positions with bit 8 reserved, and an 8-bit timeout limit. At run time it programs the limit down to 5. This makes both sides of the timeout boundary, and a long stretch that continues after its flag is cleared, reachable in a few dozen cycles. Because the source count is ten, every implemented flag, the reserved position and the arbitration-lost bit above the gap can all be driven and read in one table walk.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int SRC_W   = 10;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = SRC_W;
  localparam int LIMIT_W = 8;

  localparam logic [SRC_W-1:0]   IMPL_BITS   = 10'h2FF;
  localparam logic [LIMIT_W-1:0] LIMIT_RESET = 8'hFF;
  localparam int                 BIT_TIMEOUT = 3;

  localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_LIMIT   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_ENABLE  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_DISABLE = 8'h28;

  typedef struct packed {
    logic clrStatus;
    logic openMask;
    logic closeMask;
    logic loadLimit;
  } regStrobe_t;
endpackage

// File: rtl/irq_reg_ctrl.sv
module irq_reg_ctrl
  import irq_regs_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  output regStrobe_t    strobe
);
  always_comb begin
    strobe = '0;
    if (wrEn) begin
      unique case (wrAddr)
        OFS_STATUS:  strobe.clrStatus = 1'b1;
        OFS_ENABLE:  strobe.openMask  = 1'b1;
        OFS_DISABLE: strobe.closeMask = 1'b1;
        OFS_LIMIT:   strobe.loadLimit = 1'b1;
        default:     strobe = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_stretch_timer.sv
module irq_stretch_timer #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busStretch,
  input  logic [LW-1:0] limit,
  output logic          tmoPulse
);
  logic [LW-1:0] cnt;
  logic          fired;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      fired    <= 1'b0;
      tmoPulse <= 1'b0;
    end else begin
      tmoPulse <= 1'b0;
      if (!busStretch) begin
        cnt   <= '0;
        fired <= 1'b0;
      end else if (!fired) begin
        if (cnt >= limit) begin
          tmoPulse <= 1'b1;
          fired    <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irq_reg_datapath.sv
module irq_reg_datapath
  import irq_regs_pkg::*;
#(
  parameter int               SW    = SRC_W,
  parameter int               DW    = DATA_W,
  parameter int               AW    = ADDR_W,
  parameter int               LW    = LIMIT_W,
  parameter logic [SW-1:0]    IMPL  = IMPL_BITS,
  parameter logic [LW-1:0]    LRST  = LIMIT_RESET
) (
  input  logic          clk,
  input  logic          rstN,
  input  regStrobe_t    strobe,
  input  logic [DW-1:0] wrData,
  input  logic [SW-1:0] evtAll,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  output logic [SW-1:0] statusQ,
  output logic [SW-1:0] maskQ,
  output logic [LW-1:0] limitQ,
  output logic          irq
);
  for (genvar i = 0; i < SW; i++) begin : g_src
    if (IMPL[i]) begin : g_impl
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          statusQ[i] <= 1'b0;
        end else if (evtAll[i]) begin
          statusQ[i] <= 1'b1;
        end else if (strobe.clrStatus && wrData[i]) begin
          statusQ[i] <= 1'b0;
        end
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          maskQ[i] <= 1'b1;
        end else if (strobe.openMask && wrData[i]) begin
          maskQ[i] <= 1'b0;
        end else if (strobe.closeMask && wrData[i]) begin
          maskQ[i] <= 1'b1;
        end
      end
    end else begin : g_rsvd
      assign statusQ[i] = 1'b0;
      assign maskQ[i]   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limitQ <= LRST;
    end else if (strobe.loadLimit) begin
      limitQ <= wrData[LW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else begin
      irq <= |(statusQ & ~maskQ);
    end
  end

  always_comb begin
    case (rdAddr)
      OFS_STATUS: rdData = DW'(statusQ);
      OFS_MASK:   rdData = DW'(maskQ);
      OFS_LIMIT:  rdData = DW'(limitQ);
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_reg_group.sv
module irq_reg_group
  import irq_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [SRC_W-1:0]  evtIn,
  input  logic              busStretch,
  output logic              irq
);
  regStrobe_t         strobe;
  logic               tmoPulse;
  logic [SRC_W-1:0]   evtAll;
  logic [SRC_W-1:0]   statusQ;
  logic [SRC_W-1:0]   maskQ;
  logic [LIMIT_W-1:0] limitQ;

  irq_reg_ctrl #(.AW(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .strobe(strobe)
  );

  irq_stretch_timer #(.LW(LIMIT_W)) u_tmo (
    .clk(clk), .rstN(rstN), .busStretch(busStretch),
    .limit(limitQ), .tmoPulse(tmoPulse)
  );

  always_comb begin
    evtAll = evtIn;
    evtAll[BIT_TIMEOUT] = evtIn[BIT_TIMEOUT] | tmoPulse;
  end

  irq_reg_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .evtAll(evtAll), .rdAddr(rdAddr), .rdData(rdData),
    .statusQ(statusQ), .maskQ(maskQ), .limitQ(limitQ), .irq(irq)
  );
endmodule

// File: rtl/irq_reg_group_chk.sv
module irq_reg_group_chk
  import irq_regs_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [SRC_W-1:0]  evtAll,
  input logic [SRC_W-1:0]  statusQ,
  input logic [SRC_W-1:0]  maskQ,
  input logic              irq
);
  logic wrStat, wrOpen, wrClose;
  assign wrStat  = wrEn && (wrAddr == OFS_STATUS);
  assign wrOpen  = wrEn && (wrAddr == OFS_ENABLE);
  assign wrClose = wrEn && (wrAddr == OFS_DISABLE);

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    |(evtAll & IMPL_BITS) |=> ((statusQ & $past(evtAll & IMPL_BITS)) == $past(evtAll & IMPL_BITS)));

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrStat |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrStat |=> ((statusQ & $past(wrData[SRC_W-1:0] & ~evtAll)) == '0));

  p_event_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrStat && |(evtAll & wrData[SRC_W-1:0] & IMPL_BITS))
    |=> ((statusQ & $past(evtAll & wrData[SRC_W-1:0] & IMPL_BITS)) == $past(evtAll & wrData[SRC_W-1:0] & IMPL_BITS)));

  p_mask_open_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrOpen |=> ((maskQ & $past(wrData[SRC_W-1:0])) == '0));

  p_mask_close_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrClose |=> ((maskQ & $past(wrData[SRC_W-1:0] & IMPL_BITS)) == $past(wrData[SRC_W-1:0] & IMPL_BITS)));

  p_irq_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusQ & ~maskQ)) |=> irq);

  p_irq_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~maskQ) == '0) |=> !irq);
endmodule

bind irq_reg_group irq_reg_group_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .evtAll(evtAll), .statusQ(statusQ), .maskQ(maskQ), .irq(irq)
);

// File: tb/sim_irq_reg_group.sv
module sim_irq_reg_group;
  localparam logic [7:0] A_STAT = 8'h10, A_LIM = 8'h1C, A_MASK = 8'h20,
                         A_OPEN = 8'h24, A_CLOSE = 8'h28, A_OTHER = 8'h40;

  typedef struct packed {
    logic       wr;
    logic [7:0] addr;
    logic [9:0] data;
    logic [9:0] evt;
    logic [9:0] expStat;
    logic [9:0] expMask;
    logic [3:0] req;
  } row_t;

  localparam int NROWS = 12;
  localparam row_t ROWS [NROWS] = '{
    '{1'b0, 8'h00,    10'h000, 10'h001, 10'h001, 10'h2FF, 4'd2},  // R2 set bit0
    '{1'b0, 8'h00,    10'h000, 10'h100, 10'h001, 10'h2FF, 4'd8},  // R8 reserved event
    '{1'b0, 8'h00,    10'h000, 10'h2FE, 10'h2FF, 10'h2FF, 4'd2},  // R2 all others
    '{1'b1, A_STAT,   10'h00C, 10'h000, 10'h2F3, 10'h2FF, 4'd3},  // R3 partial clear
    '{1'b1, A_STAT,   10'h001, 10'h001, 10'h2F3, 10'h2FF, 4'd4},  // R4 event wins
    '{1'b1, A_OPEN,   10'h005, 10'h000, 10'h2F3, 10'h2FA, 4'd5},  // R5
    '{1'b1, A_OPEN,   10'h200, 10'h000, 10'h2F3, 10'h0FA, 4'd5},  // R5 bit9
    '{1'b1, A_CLOSE,  10'h001, 10'h000, 10'h2F3, 10'h0FB, 4'd6},  // R6
    '{1'b1, A_OTHER,  10'h3FF, 10'h000, 10'h2F3, 10'h0FB, 4'd11}, // R11
    '{1'b1, A_STAT,   10'h3FF, 10'h000, 10'h000, 10'h0FB, 4'd3},  // R3 clear all
    '{1'b1, A_OPEN,   10'h3FF, 10'h000, 10'h000, 10'h000, 4'd5},  // R5 open all, R8 rsvd 0
    '{1'b1, A_CLOSE,  10'h3FF, 10'h000, 10'h000, 10'h2FF, 4'd6}   // R6 close all
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [9:0] wrData = '0;
  logic [7:0] rdAddr = '0;
  logic [9:0] rdData;
  logic [9:0] evtIn = '0;
  logic       busStretch = 1'b0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_reg_group u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evtIn(evtIn),
    .busStretch(busStretch), .irq(irq)
  );

  task automatic check(string req, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [9:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic wr(input logic [7:0] a, input logic [9:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(1);
  endtask

  task automatic checkReset(string tag);
    logic [9:0] v;
    rd(A_STAT, v); check(tag, v, 10'h000);
    rd(A_MASK, v); check(tag, v, 10'h2FF);
    rd(A_LIM, v);  check(tag, v, 10'h0FF);
    check(tag, {9'd0, irq}, 10'h000);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [9:0] v;
    idle(3);
    rstN = 1'b1;
    idle(1);
    checkReset("R1");

    // table walk: R2 R3 R4 R5 R6 R8 R11
    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      wrEn = ROWS[i].wr; wrAddr = ROWS[i].addr; wrData = ROWS[i].data;
      evtIn = ROWS[i].evt;
      @(negedge clk);
      wrEn = 1'b0; wrAddr = '0; wrData = '0; evtIn = '0;
      rd(A_STAT, v); check($sformatf("R%0d row %0d flags", ROWS[i].req, i), v, ROWS[i].expStat);
      rd(A_MASK, v); check($sformatf("R%0d row %0d mask", ROWS[i].req, i), v, ROWS[i].expMask);
    end

    // R7 interrupt timing
    doReset();
    wr(A_OPEN, 10'h004);
    @(negedge clk); evtIn = 10'h002;
    @(negedge clk); evtIn = '0;
    idle(2);
    check("R7 masked flag", {9'd0, irq}, 10'h000);
    @(negedge clk); evtIn = 10'h004;
    @(posedge clk); #1;
    check("R7 same edge", {9'd0, irq}, 10'h000);
    @(negedge clk); evtIn = '0;
    @(posedge clk); #1;
    check("R7 one later", {9'd0, irq}, 10'h001);
    @(negedge clk); wrEn = 1'b1; wrAddr = A_STAT; wrData = 10'h004;
    @(posedge clk); #1;
    check("R7 clear edge", {9'd0, irq}, 10'h001);
    @(negedge clk); wrEn = 1'b0; wrAddr = '0; wrData = '0;
    @(posedge clk); #1;
    check("R7 after clear", {9'd0, irq}, 10'h000);
    wr(A_OPEN, 10'h002);
    @(posedge clk); #1;
    check("R7 open masked flag", {9'd0, irq}, 10'h001);
    wr(A_CLOSE, 10'h002);
    @(posedge clk); #1;
    check("R7 close again", {9'd0, irq}, 10'h000);

    // R9 timeout limit and boundary
    wr(A_STAT, 10'h3FF);
    wr(A_LIM, 10'h305);
    rd(A_LIM, v); check("R9 limit readback", v, 10'h005);
    @(negedge clk); busStretch = 1'b1;
    idle(5);
    busStretch = 1'b0;
    idle(3);
    rd(A_STAT, v); check("R9 stretch equal to limit", v & 10'h008, 10'h000);
    busStretch = 1'b1;
    idle(6);
    busStretch = 1'b0;
    idle(3);
    rd(A_STAT, v); check("R9 stretch beyond limit", v & 10'h008, 10'h008);

    // R10 one timeout per stretch episode
    wr(A_STAT, 10'h008);
    @(negedge clk); busStretch = 1'b1;
    idle(10);
    rd(A_STAT, v); check("R10 first raise", v & 10'h008, 10'h008);
    wr(A_STAT, 10'h008);
    idle(12);
    rd(A_STAT, v); check("R10 no repeat while held", v & 10'h008, 10'h000);
    busStretch = 1'b0;
    idle(3);
    rd(A_STAT, v); check("R10 after release", v & 10'h008, 10'h000);

    // R11 limit untouched by foreign write, then R1 on reset
    wr(A_OTHER, 10'h3FF);
    rd(A_LIM, v); check("R11 limit kept", v, 10'h005);
    doReset();
    checkReset("R1 second reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule